// File: doc/BRIEF.md
# DDR SDRAM Per-Bank Command Timing Monitor

This block watches the command stream sent to a four-bank double-data-rate SDRAM running on a 5 ns clock. Each cycle it may receive one decoded command with its bank number and the auto-precharge/all-banks address flag. It keeps an open/closed flag for every bank and a set of saturating age counters. Per bank, these count cycles since the last activate, the last precharge and the last write. Shared across banks, they count cycles since the last activate, the last write and the last mode-register load. From these it decides whether the command breaks a state or spacing rule.

Minimum spacings are given as nanosecond parameters and turned into clock counts by rounding up against the clock period. With the defaults the counts are: activate-to-access 4, activate-to-precharge 8 (14000 maximum), activate-to-activate on one bank 12, precharge-to-activate 4, activate-to-activate across banks 2, write recovery 3, write-to-read 2, and mode load 2. A distance of k means that the later command is sampled k clock edges after the earlier one. Any broken rule raises a one-cycle flag that carries a rule code and the bank field of the offending command. The monitor never blocks or alters traffic. It updates its bank model from every command it sees, including commands that violate a rule.

Top module: `ddr_timing_monitor`

## Requirements
- R1: Command codes on `cmd_op` are 0 no-op, 1 activate, 2 read, 3 write, 4 precharge, 5 auto refresh, 6 mode load; `cmd_valid` low means no command. After reset all banks are closed, all ages are saturated (no spacing rule can fire), and `viol_pulse`, `viol_code`, `viol_bank` are zero.
- R2: Code 1 (state): a read or write to a closed bank, an activate to an open bank, or a refresh or mode load while any bank is open.
- R3: Code 2: any command other than a no-op sampled fewer than 2 cycles after a mode load.
- R4: Code 3: a read or write to an open bank fewer than 4 cycles after that bank's activate; an auto-precharging access at exactly 4 cycles is legal.
- R5: Code 4: a precharge that closes a bank fewer than 8 cycles after its activate. Code 5: a precharge that closes a bank more than 14000 cycles after its activate.
- R6: Code 6: an activate fewer than 12 cycles after the previous activate of the same bank.
- R7: Code 7: an activate fewer than 4 cycles after that bank was closed, or a refresh or mode load fewer than 4 cycles after any bank was closed.
- R8: Code 8: an activate fewer than 2 cycles after an activate to a different bank.
- R9: Code 9: a precharge that closes a bank fewer than 3 cycles after a write command to that bank.
- R10: Code 10: a read fewer than 2 cycles after a write to any bank.
- R11: The result for a command sampled at edge n appears on the outputs right after edge n and lasts one cycle. When several rules break at once the lowest code is reported. `viol_bank` is the command's bank field during a flag and 0 otherwise.
- R12: A precharge with the address flag 1 closes every open bank. A precharge with the flag 0 acts on the selected bank only. A precharge to a closed bank changes no state and never flags.
- R13: A read or write with the address flag 1 closes its bank at that command and starts that bank's precharge age.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 3 | Command code (R1) |
| cmd_bank | input | 2 | Target bank |
| cmd_a10 | input | 1 | Auto-precharge on access, all banks on precharge |
| viol_pulse | output | 1 | One-cycle violation flag |
| viol_code | output | 4 | Rule code of the violation |
| viol_bank | output | 2 | Bank field of the offending command |

## Verification
Each spacing rule is swept over command distances from 1 up to just beyond its limit, starting from a fresh reset. The expected code is computed from the distance, so the sweep shows exactly where the boundary lies. For activate-to-access this is repeated on every bank with both reads and writes. Sequences in which two rules fail together (same-bank reactivation after auto-precharge, a closed-bank access right after a mode load) show whether the lowest code wins. Precharge to a closed bank and all-bank precharge with mixed open banks are followed by accesses that reveal whether the right banks stayed open. The upper activate-to-precharge limit is tried one cycle on each side of 14000.

// File: rtl/ddrmon_pkg.sv
// Shared types for the DDR command timing monitor.
// Assumes one command per clock and at most NUM_BANKS banks.
package ddrmon_pkg;
    typedef enum logic [2:0] {
        OP_NOP = 3'd0,
        OP_ACT = 3'd1,
        OP_RD  = 3'd2,
        OP_WR  = 3'd3,
        OP_PRE = 3'd4,
        OP_REF = 3'd5,
        OP_LMR = 3'd6
    } op_e;

    // Listed in priority order: lowest non-zero value wins.
    typedef enum logic [3:0] {
        V_NONE    = 4'd0,
        V_STATE   = 4'd1,
        V_MRD     = 4'd2,
        V_RCD     = 4'd3,
        V_RAS_MIN = 4'd4,
        V_RAS_MAX = 4'd5,
        V_RC      = 4'd6,
        V_RP      = 4'd7,
        V_RRD     = 4'd8,
        V_WR      = 4'd9,
        V_WTR     = 4'd10
    } viol_e;

    // Smallest whole number of clocks covering a time in ns.
    function automatic int unsigned ns_to_ck_up(int unsigned ns, int unsigned clk_ps);
        return (ns * 1000 + clk_ps - 1) / clk_ps;
    endfunction

    // Largest whole number of clocks not exceeding a time in ns.
    function automatic int unsigned ns_to_ck_dn(int unsigned ns, int unsigned clk_ps);
        return (ns * 1000) / clk_ps;
    endfunction
endpackage

// File: rtl/ddrmon_age_ctr.sv
// Saturating age counter: counts clock edges since the last restart.
// A restart loads 1, so the value equals the edge distance to the event.
// Reset loads SAT so that no spacing rule fires before any event.
module ddrmon_age_ctr #(
    parameter int unsigned CW  = 8,
    parameter int unsigned SAT = 255
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    output logic [CW-1:0] age
);
    // Restart on event, otherwise count up and stop at SAT.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age <= CW'(SAT);
        end else if (restart) begin
            age <= CW'(1);
        end else if (age != CW'(SAT)) begin
            age <= age + CW'(1);
        end
    end
endmodule

// File: rtl/ddrmon_bank_state.sv
// State of one bank: open flag plus activate, close and write ages.
// Assumes open and close requests never arrive in the same cycle.
module ddrmon_bank_state #(
    parameter int unsigned CW  = 8,
    parameter int unsigned SAT = 255
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          do_open,
    input  logic          do_close,
    input  logic          do_write,
    output logic          is_open,
    output logic [CW-1:0] age_act,
    output logic [CW-1:0] age_pre,
    output logic [CW-1:0] age_wr
);
    // Track whether a row is open in this bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_open <= 1'b0;
        end else if (do_open) begin
            is_open <= 1'b1;
        end else if (do_close) begin
            is_open <= 1'b0;
        end
    end

    ddrmon_age_ctr #(.CW(CW), .SAT(SAT)) act_ctr_i (
        .clk(clk), .rst_n(rst_n), .restart(do_open), .age(age_act));
    ddrmon_age_ctr #(.CW(CW), .SAT(SAT)) pre_ctr_i (
        .clk(clk), .rst_n(rst_n), .restart(do_close), .age(age_pre));
    ddrmon_age_ctr #(.CW(CW), .SAT(SAT)) wr_ctr_i (
        .clk(clk), .rst_n(rst_n), .restart(do_write), .age(age_wr));
endmodule

// File: rtl/ddrmon_rule_eval.sv
// Combinational rule evaluation for the current command.
// Uses bank and shared ages; returns the lowest-numbered broken rule.
module ddrmon_rule_eval
    import ddrmon_pkg::*;
#(
    parameter int unsigned NB      = 4,
    parameter int unsigned BW      = 2,
    parameter int unsigned CW      = 8,
    parameter int unsigned RCD_CK  = 4,
    parameter int unsigned RASN_CK = 8,
    parameter int unsigned RASX_CK = 14000,
    parameter int unsigned RC_CK   = 12,
    parameter int unsigned RP_CK   = 4,
    parameter int unsigned RRD_CK  = 2,
    parameter int unsigned WR_CK   = 3,
    parameter int unsigned WTR_CK  = 2,
    parameter int unsigned MRD_CK  = 2
) (
    input  logic                  valid,
    input  op_e                   op,
    input  logic [BW-1:0]         bank,
    input  logic                  a10,
    input  logic [NB-1:0]         open_v,
    input  logic [NB-1:0][CW-1:0] age_act,
    input  logic [NB-1:0][CW-1:0] age_pre,
    input  logic [NB-1:0][CW-1:0] age_wr,
    input  logic [CW-1:0]         age_any_act,
    input  logic [BW-1:0]         last_act_bank,
    input  logic [CW-1:0]         age_any_wr,
    input  logic [CW-1:0]         age_lmr,
    output viol_e                 code
);
    logic is_acc, is_glob, is_act, sel_open;
    logic ras_min_hit, ras_max_hit, wr_hit, rp_any;
    logic [NB-1:0] pre_hit;

    // Gather per-bank rule hits for precharge and global commands.
    always_comb begin
        is_acc      = valid && (op == OP_RD || op == OP_WR);
        is_glob     = valid && (op == OP_REF || op == OP_LMR);
        is_act      = valid && (op == OP_ACT);
        sel_open    = open_v[bank];
        ras_min_hit = 1'b0;
        ras_max_hit = 1'b0;
        wr_hit      = 1'b0;
        rp_any      = 1'b0;
        for (int b = 0; b < NB; b++) begin
            pre_hit[b]  = valid && (op == OP_PRE) && open_v[b] &&
                          (a10 || bank == BW'(b));
            ras_min_hit = ras_min_hit | (pre_hit[b] && age_act[b] < CW'(RASN_CK));
            ras_max_hit = ras_max_hit | (pre_hit[b] && age_act[b] > CW'(RASX_CK));
            wr_hit      = wr_hit      | (pre_hit[b] && age_wr[b]  < CW'(WR_CK));
            rp_any      = rp_any      | (age_pre[b] < CW'(RP_CK));
        end
    end

    // Priority encode the broken rules, lowest code first.
    always_comb begin
        code = V_NONE;
        if ((is_acc && !sel_open) || (is_act && sel_open) || (is_glob && (|open_v)))
            code = V_STATE;
        else if (valid && op != OP_NOP && age_lmr < CW'(MRD_CK))
            code = V_MRD;
        else if (is_acc && age_act[bank] < CW'(RCD_CK))
            code = V_RCD;
        else if (ras_min_hit)
            code = V_RAS_MIN;
        else if (ras_max_hit)
            code = V_RAS_MAX;
        else if (is_act && age_act[bank] < CW'(RC_CK))
            code = V_RC;
        else if ((is_act && age_pre[bank] < CW'(RP_CK)) || (is_glob && rp_any))
            code = V_RP;
        else if (is_act && last_act_bank != bank && age_any_act < CW'(RRD_CK))
            code = V_RRD;
        else if (wr_hit)
            code = V_WR;
        else if (valid && op == OP_RD && age_any_wr < CW'(WTR_CK))
            code = V_WTR;
    end
endmodule

// File: rtl/ddr_timing_monitor.sv
// Top of the DDR command timing monitor.
// Converts ns limits to clocks, keeps per-bank and shared ages, and
// registers a one-cycle violation flag with code and bank.
// Assumes commands are already decoded and arrive one per clock.
module ddr_timing_monitor
    import ddrmon_pkg::*;
#(
    parameter int unsigned NUM_BANKS  = 4,
    parameter int unsigned CLK_PS     = 5000,
    parameter int unsigned T_RCD_NS   = 20,
    parameter int unsigned T_RASN_NS  = 40,
    parameter int unsigned T_RASX_NS  = 70000,
    parameter int unsigned T_RC_NS    = 60,
    parameter int unsigned T_RP_NS    = 20,
    parameter int unsigned T_RRD_NS   = 10,
    parameter int unsigned T_WR_NS    = 15,
    parameter int unsigned T_MRD_NS   = 10,
    parameter int unsigned WTR_CK     = 2,
    localparam int unsigned BW        = $clog2(NUM_BANKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic [BW-1:0] cmd_bank,
    input  logic          cmd_a10,
    output logic          viol_pulse,
    output logic [3:0]    viol_code,
    output logic [BW-1:0] viol_bank
);
    localparam int unsigned RCD_CK  = ns_to_ck_up(T_RCD_NS, CLK_PS);
    localparam int unsigned RASN_CK = ns_to_ck_up(T_RASN_NS, CLK_PS);
    localparam int unsigned RASX_CK = ns_to_ck_dn(T_RASX_NS, CLK_PS);
    localparam int unsigned RC_CK   = ns_to_ck_up(T_RC_NS, CLK_PS);
    localparam int unsigned RP_CK   = ns_to_ck_up(T_RP_NS, CLK_PS);
    localparam int unsigned RRD_CK  = ns_to_ck_up(T_RRD_NS, CLK_PS);
    localparam int unsigned WR_CK   = ns_to_ck_up(T_WR_NS, CLK_PS);
    localparam int unsigned MRD_CK  = ns_to_ck_up(T_MRD_NS, CLK_PS);
    localparam int unsigned SAT     = RASX_CK + 1;
    localparam int unsigned CW      = $clog2(SAT + 1);

    op_e                   op;
    logic [NUM_BANKS-1:0]  open_v, do_open, do_close, do_write;
    logic [NUM_BANKS-1:0][CW-1:0] age_act, age_pre, age_wr;
    logic [CW-1:0]         age_any_act, age_any_wr, age_lmr;
    logic [BW-1:0]         last_act_bank;
    viol_e                 code_nx;

    assign op = op_e'(cmd_op);

    // Derive per-bank open, close and write events from the command.
    always_comb begin
        for (int b = 0; b < NUM_BANKS; b++) begin
            do_open[b]  = cmd_valid && op == OP_ACT && cmd_bank == BW'(b);
            do_write[b] = cmd_valid && op == OP_WR  && cmd_bank == BW'(b);
            do_close[b] = open_v[b] && cmd_valid &&
                          ((op == OP_PRE && (cmd_a10 || cmd_bank == BW'(b))) ||
                           ((op == OP_RD || op == OP_WR) && cmd_a10 && cmd_bank == BW'(b)));
        end
    end

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        ddrmon_bank_state #(.CW(CW), .SAT(SAT)) bank_i (
            .clk(clk), .rst_n(rst_n),
            .do_open(do_open[g]), .do_close(do_close[g]), .do_write(do_write[g]),
            .is_open(open_v[g]), .age_act(age_act[g]),
            .age_pre(age_pre[g]), .age_wr(age_wr[g]));
    end

    ddrmon_age_ctr #(.CW(CW), .SAT(SAT)) any_act_i (
        .clk(clk), .rst_n(rst_n), .restart(|do_open), .age(age_any_act));
    ddrmon_age_ctr #(.CW(CW), .SAT(SAT)) any_wr_i (
        .clk(clk), .rst_n(rst_n), .restart(|do_write), .age(age_any_wr));
    ddrmon_age_ctr #(.CW(CW), .SAT(SAT)) lmr_i (
        .clk(clk), .rst_n(rst_n), .restart(cmd_valid && op == OP_LMR), .age(age_lmr));

    // Remember which bank received the most recent activate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_act_bank <= '0;
        end else if (cmd_valid && op == OP_ACT) begin
            last_act_bank <= cmd_bank;
        end
    end

    ddrmon_rule_eval #(
        .NB(NUM_BANKS), .BW(BW), .CW(CW),
        .RCD_CK(RCD_CK), .RASN_CK(RASN_CK), .RASX_CK(RASX_CK), .RC_CK(RC_CK),
        .RP_CK(RP_CK), .RRD_CK(RRD_CK), .WR_CK(WR_CK), .WTR_CK(WTR_CK),
        .MRD_CK(MRD_CK)
    ) eval_i (
        .valid(cmd_valid), .op(op), .bank(cmd_bank), .a10(cmd_a10),
        .open_v(open_v), .age_act(age_act), .age_pre(age_pre), .age_wr(age_wr),
        .age_any_act(age_any_act), .last_act_bank(last_act_bank),
        .age_any_wr(age_any_wr), .age_lmr(age_lmr), .code(code_nx));

    // Register the verdict as a one-cycle flag with code and bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol_pulse <= 1'b0;
            viol_code  <= 4'd0;
            viol_bank  <= '0;
        end else begin
            viol_pulse <= (code_nx != V_NONE);
            viol_code  <= code_nx;
            viol_bank  <= (code_nx != V_NONE) ? cmd_bank : '0;
        end
    end
endmodule

// File: rtl/ddrmon_checker.sv
// Protocol properties of the timing monitor, observed at its ports.
// Assumes cmd_valid is low while reset is asserted.
module ddrmon_checker #(
    parameter int unsigned BW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic [2:0]    cmd_op,
    input logic [BW-1:0] cmd_bank,
    input logic          viol_pulse,
    input logic [3:0]    viol_code,
    input logic [BW-1:0] viol_bank
);
    // R11: no command, no flag.
    a_r11_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !viol_pulse);

    // R11: flag and code agree, bank zero when quiet.
    a_r11_code_matches_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_pulse |-> viol_code != 4'd0) and
        (!viol_pulse |-> (viol_code == 4'd0 && viol_bank == '0)));

    // R3: any real command right after a mode load is flagged.
    a_r3_mode_load_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op != 3'd0 && $past(cmd_valid) && $past(cmd_op) == 3'd6)
        |=> viol_pulse);

    // R4: access to a bank one cycle after its activate is flagged.
    a_r4_access_after_act: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_op == 3'd2 || cmd_op == 3'd3) && $past(cmd_valid) &&
         $past(cmd_op) == 3'd1 && $past(cmd_bank) == cmd_bank)
        |=> (viol_pulse && viol_bank == $past(cmd_bank)));

    // R6: two activates to one bank on consecutive cycles are flagged.
    a_r6_same_bank_reactivate: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd1 && $past(cmd_valid) && $past(cmd_op) == 3'd1 &&
         $past(cmd_bank) == cmd_bank) |=> viol_pulse);

    // R8: activates to two banks on consecutive cycles are flagged.
    a_r8_cross_bank_activate: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd1 && $past(cmd_valid) && $past(cmd_op) == 3'd1 &&
         $past(cmd_bank) != cmd_bank) |=> viol_pulse);
endmodule

bind ddr_timing_monitor ddrmon_checker #(.BW(BW)) chk_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .viol_pulse(viol_pulse), .viol_code(viol_code),
    .viol_bank(viol_bank));

// File: tb/ddr_timing_monitor_tb_top.sv
// Sweep bench for the DDR command timing monitor: every spacing rule is
// tried at distances around its limit, expectations computed from the rules.
module ddr_timing_monitor_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int OP_NOP = 0, OP_ACT = 1, OP_RD = 2, OP_WR = 3,
                   OP_PRE = 4, OP_REF = 5, OP_LMR = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [1:0] cmd_bank = 2'd0;
    logic       cmd_a10 = 1'b0;
    logic       viol_pulse;
    logic [3:0] viol_code;
    logic [1:0] viol_bank;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ddr_timing_monitor dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bank(cmd_bank), .cmd_a10(cmd_a10), .viol_pulse(viol_pulse),
        .viol_code(viol_code), .viol_bank(viol_bank));

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cmd_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Issue one command at a negedge, check the verdict after the next edge.
    task automatic cmd(input int op, input int bank, input bit a10,
                       input int exp_code, input string req);
        logic       e_p;
        logic [1:0] e_b;
        cmd_valid = 1'b1;
        cmd_op    = 3'(op);
        cmd_bank  = 2'(bank);
        cmd_a10   = a10;
        @(posedge clk);
        #1;
        e_p = (exp_code != 0);
        e_b = e_p ? 2'(bank) : 2'd0;
        checks++;
        if (viol_pulse !== e_p || viol_code !== 4'(exp_code) || viol_bank !== e_b) begin
            errors++;
            $display("FAIL %s: op %0d bank %0d got pulse %0b code %0d bank %0d, expected pulse %0b code %0d bank %0d",
                     req, op, bank, viol_pulse, viol_code, viol_bank, e_p, exp_code, e_b);
        end
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // Make the next command land k edges after the previous one.
    task automatic gap(input int k);
        repeat (k - 1) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, got hang, expected finish");
            finish_run();
        end
    end

    initial begin
        // R1: reset state and a legal first command.
        do_reset();
        #1;
        checks++;
        if (viol_pulse !== 1'b0 || viol_code !== 4'd0 || viol_bank !== 2'd0) begin
            errors++;
            $display("FAIL R1: reset outputs got %0b/%0d/%0d expected 0/0/0",
                     viol_pulse, viol_code, viol_bank);
        end
        @(negedge clk);
        cmd(OP_ACT, 0, 0, 0, "R1");

        // R4: activate to access sweep on every bank, reads and writes.
        for (int b = 0; b < 4; b++) begin
            for (int w = 0; w < 2; w++) begin
                for (int k = 1; k <= 5; k++) begin
                    do_reset();
                    cmd(OP_ACT, b, 0, 0, "R4");
                    gap(k);
                    cmd(w ? OP_WR : OP_RD, b, 0, (k < 4) ? 3 : 0, "R4");
                end
            end
        end

        // R5: activate to precharge minimum.
        for (int k = 1; k <= 9; k++) begin
            do_reset();
            cmd(OP_ACT, 2, 0, 0, "R5");
            gap(k);
            cmd(OP_PRE, 2, 0, (k < 8) ? 4 : 0, "R5");
        end

        // R5: activate to precharge maximum, one cycle each side.
        for (int k = 14000; k <= 14001; k++) begin
            do_reset();
            cmd(OP_ACT, 1, 0, 0, "R5");
            gap(k);
            cmd(OP_PRE, 1, 0, (k > 14000) ? 5 : 0, "R5");
        end

        // R6, R11, R13: reactivation after auto-precharge; tRC beats tRP.
        for (int m = 1; m <= 9; m++) begin
            do_reset();
            cmd(OP_ACT, 3, 0, 0, "R13");
            gap(4);
            cmd(OP_RD, 3, 1, 0, "R13");
            gap(m);
            cmd(OP_ACT, 3, 0, (4 + m < 12) ? 6 : 0, (m < 4) ? "R11" : "R6");
        end

        // R7: precharge to activate on the same bank.
        for (int m = 1; m <= 5; m++) begin
            do_reset();
            cmd(OP_ACT, 0, 0, 0, "R7");
            gap(20);
            cmd(OP_PRE, 0, 0, 0, "R7");
            gap(m);
            cmd(OP_ACT, 0, 0, (m < 4) ? 7 : 0, "R7");
        end

        // R7: precharge to refresh across banks.
        for (int m = 1; m <= 5; m++) begin
            do_reset();
            cmd(OP_ACT, 2, 0, 0, "R7");
            gap(20);
            cmd(OP_PRE, 2, 0, 0, "R7");
            gap(m);
            cmd(OP_REF, 0, 0, (m < 4) ? 7 : 0, "R7");
        end

        // R8: activate to activate across banks.
        for (int k = 1; k <= 3; k++) begin
            do_reset();
            cmd(OP_ACT, 0, 0, 0, "R8");
            gap(k);
            cmd(OP_ACT, 1, 0, (k < 2) ? 8 : 0, "R8");
        end

        // R9: write recovery before precharge.
        for (int m = 1; m <= 4; m++) begin
            do_reset();
            cmd(OP_ACT, 1, 0, 0, "R9");
            gap(10);
            cmd(OP_WR, 1, 0, 0, "R9");
            gap(m);
            cmd(OP_PRE, 1, 0, (m < 3) ? 9 : 0, "R9");
        end

        // R10: write to read delay.
        for (int m = 1; m <= 3; m++) begin
            do_reset();
            cmd(OP_ACT, 0, 0, 0, "R10");
            gap(4);
            cmd(OP_WR, 0, 0, 0, "R10");
            gap(m);
            cmd(OP_RD, 0, 0, (m < 2) ? 10 : 0, "R10");
        end

        // R3: mode load spacing.
        for (int k = 1; k <= 3; k++) begin
            do_reset();
            cmd(OP_LMR, 0, 0, 0, "R3");
            gap(k);
            cmd(OP_REF, 0, 0, (k < 2) ? 2 : 0, "R3");
        end

        // R2: state violations, and R11 state winning over mode spacing.
        do_reset();
        cmd(OP_RD, 2, 0, 1, "R2");
        do_reset();
        cmd(OP_ACT, 0, 0, 0, "R2");
        gap(20);
        cmd(OP_ACT, 0, 0, 1, "R2");
        gap(5);
        cmd(OP_REF, 0, 0, 1, "R2");
        do_reset();
        cmd(OP_LMR, 0, 0, 0, "R11");
        cmd(OP_WR, 3, 0, 1, "R11");

        // R12: precharge to a closed bank leaves the open bank alone.
        do_reset();
        cmd(OP_ACT, 0, 0, 0, "R12");
        cmd(OP_PRE, 2, 0, 0, "R12");
        gap(4);
        cmd(OP_RD, 0, 0, 0, "R12");
        // R12: all-bank precharge closes every open bank.
        do_reset();
        cmd(OP_ACT, 0, 0, 0, "R12");
        gap(10);
        cmd(OP_ACT, 1, 0, 0, "R12");
        gap(2);
        cmd(OP_PRE, 3, 1, 4, "R12");
        gap(5);
        cmd(OP_RD, 0, 0, 1, "R12");
        cmd(OP_RD, 1, 0, 1, "R12");

        // R13: auto-precharge at exactly tRCD is legal and closes the bank.
        do_reset();
        cmd(OP_ACT, 2, 0, 0, "R13");
        gap(4);
        cmd(OP_WR, 2, 1, 0, "R13");
        gap(5);
        cmd(OP_RD, 2, 0, 1, "R13");

        done = 1'b1;
        finish_run();
    end
endmodule